// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block gathers up to 32 level-sensitive peripheral interrupt lines and one non-maskable line. For each maskable line it keeps an enable bit, a pending bit, an active bit and a small programmable priority. Every cycle it picks the most urgent enabled pending request. It offers that request to the core only when it is strictly more urgent than the level that is running now.

The core answers an offer with a one-cycle acknowledge. The block then moves the winner from pending to active and pushes its level onto an internal stack of running levels. A one-cycle exception-return pulse pops the innermost entry. Handlers therefore nest and unwind in hardware, with no software decision involved. A word-wide register write port programs enables, priorities and software set/clear of pending bits. A combinational read port returns the same state.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all enables, pending bits, active bits and priorities read as zero, `reqValid` is low, and `runLevel` is the idle code (all ones).
- R2: A maskable line that is high while enabled sets its pending bit on the next clock edge. The request is then offered with exception number 16 + line index. The non-maskable source uses exception number 2.
- R3: The priority of line i sits in byte i%4 of the word at address 8 + i/4. Only the top PRIO_BITS bits of each byte are stored (bits 7:6 by default). The lower bits read as zero and ignore writes.
- R4: Among enabled pending lines, the lowest stored priority value wins. When values are equal, the lowest line index wins.
- R5: A request is offered only when its level is numerically lower than `runLevel`. A request at an equal or lower urgency stays pending and is offered once returns bring `runLevel` above it.
- R6: Acknowledge while `reqValid` is high clears the winner's pending bit, sets its active bit (read at address 4, bit i), and makes `runLevel` the winner's level. That level is the stored priority + 1 for a maskable line and 0 for the non-maskable source.
- R7: An exception return clears the active bit of the innermost handler and restores the previous `runLevel`. The previous level is the idle code when no handler remains.
- R8: Writing ones to address 0 or 1 sets or clears the matching enable bits. Writing ones to address 2 or 3 sets or clears the matching pending bits. Reads of addresses 0/1 return the enables, and reads of addresses 2/3 return the pending bits.
- R9: A disabled line takes no part in arbitration, but its pending bit is kept. A disabled line that is high does not set its pending bit.
- R10: The non-maskable source needs no enable. It preempts any maskable handler, and it does not preempt itself.
- R11: An acknowledge while `reqValid` is low changes nothing. An exception return when no handler is active changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | NUM_IRQ | Level-sensitive maskable interrupt lines |
| nmiIn | input | 1 | Non-maskable interrupt line |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| reqValid | output | 1 | A preempting request is offered |
| reqExcNum | output | EXC_W | Exception number of the offered request |
| ack | input | 1 | Core accepts the offered request |
| excReturn | input | 1 | Core returns from the innermost handler |
| runLevel | output | PRIO_BITS+1 | Level now executing (0 non-maskable, p+1 maskable, all ones idle) |

## Verification
The bench builds the block with its defaults: 32 lines and two stored priority bits. This puts the top line (exception 47), every priority word up to address 15, and all four maskable levels within reach. The nesting stack can then be driven to its full depth with the non-maskable source on top. The tests cover ties between equal priorities, equal-level requests that must wait, preemption two deep, and masking with a pending bit held. They also cover non-maskable entry over a running handler, and acknowledges and returns that must be ignored.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  localparam int IDX_W        = 5;
  localparam int EXC_NMI      = 2;
  localparam int EXC_IRQ_BASE = 16;

  localparam int ADDR_EN_SET   = 0;
  localparam int ADDR_EN_CLR   = 1;
  localparam int ADDR_PEND_SET = 2;
  localparam int ADDR_PEND_CLR = 3;
  localparam int ADDR_ACTIVE   = 4;
  localparam int ADDR_PRIO     = 8;

  typedef struct packed {
    logic             ackIrq;
    logic [IDX_W-1:0] ackIdx;
    logic             ackNmi;
    logic             retIrq;
    logic [IDX_W-1:0] retIdx;
  } dpStrobe_t;
endpackage

// File: rtl/irq_nest_arb.sv
`timescale 1ns/1ps
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2
) (
  input  logic [NUM_IRQ-1:0]                req,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
  output logic                              winValid,
  output logic [IDX_W-1:0]                  winIdx,
  output logic [PRIO_BITS-1:0]              winPrio
);
  // Ascending scan with a strict compare: an equal value never displaces
  // an earlier (lower-index) winner.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req[i] && (!winValid || prio[i] < winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_dp.sv
`timescale 1ns/1ps
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic                 nmiIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  dpStrobe_t            strb,
  output logic                 bestValid,
  output logic [IDX_W-1:0]     bestIdx,
  output logic [PRIO_BITS-1:0] bestPrio,
  output logic                 nmiPend
);
  logic [NUM_IRQ-1:0]                enReg, pendReg, actReg;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prioArr;

  logic wrEnSet, wrEnClr, wrPendSet, wrPendClr;
  assign wrEnSet   = wrEn && addr == ADDR_W'(ADDR_EN_SET);
  assign wrEnClr   = wrEn && addr == ADDR_W'(ADDR_EN_CLR);
  assign wrPendSet = wrEn && addr == ADDR_W'(ADDR_PEND_SET);
  assign wrPendClr = wrEn && addr == ADDR_W'(ADDR_PEND_CLR);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic                 pendQ, enQ, actQ, pendNxt;
    logic [PRIO_BITS-1:0] prioQ;
    logic                 ackHit, retHit, prioHit;

    assign ackHit  = strb.ackIrq && strb.ackIdx == IDX_W'(i);
    assign retHit  = strb.retIrq && strb.retIdx == IDX_W'(i);
    assign prioHit = wrEn && addr == ADDR_W'(ADDR_PRIO + i / 4);

    // Sets first, clears last: a clear wins in its own cycle.
    always_comb begin
      pendNxt = pendQ;
      if (irqIn[i] && enQ)      pendNxt = 1'b1;
      if (wrPendSet && wrData[i]) pendNxt = 1'b1;
      if (wrPendClr && wrData[i]) pendNxt = 1'b0;
      if (ackHit)               pendNxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        enQ   <= 1'b0;
        actQ  <= 1'b0;
        prioQ <= '0;
      end else begin
        pendQ <= pendNxt;
        if (wrEnSet && wrData[i])      enQ <= 1'b1;
        else if (wrEnClr && wrData[i]) enQ <= 1'b0;
        if (ackHit)      actQ <= 1'b1;
        else if (retHit) actQ <= 1'b0;
        if (prioHit) prioQ <= wrData[(i % 4) * 8 + 7 -: PRIO_BITS];
      end
    end

    assign pendReg[i] = pendQ;
    assign enReg[i]   = enQ;
    assign actReg[i]  = actQ;
    assign prioArr[i] = prioQ;
  end

  logic nmiPendQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            nmiPendQ <= 1'b0;
    else if (strb.ackNmi) nmiPendQ <= 1'b0;
    else if (nmiIn)       nmiPendQ <= 1'b1;
  end
  assign nmiPend = nmiPendQ;

  irq_nest_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
    .req      (pendReg & enReg),
    .prio     (prioArr),
    .winValid (bestValid),
    .winIdx   (bestIdx),
    .winPrio  (bestPrio)
  );

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_EN_SET) || addr == ADDR_W'(ADDR_EN_CLR))
      rdData[NUM_IRQ-1:0] = enReg;
    else if (addr == ADDR_W'(ADDR_PEND_SET) || addr == ADDR_W'(ADDR_PEND_CLR))
      rdData[NUM_IRQ-1:0] = pendReg;
    else if (addr == ADDR_W'(ADDR_ACTIVE))
      rdData[NUM_IRQ-1:0] = actReg;
    else begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr == ADDR_W'(ADDR_PRIO + i / 4))
          rdData[(i % 4) * 8 + 7 -: PRIO_BITS] = prioArr[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_ctl.sv
`timescale 1ns/1ps
module irq_nest_ctl
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  parameter int EXC_W     = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bestValid,
  input  logic [IDX_W-1:0]     bestIdx,
  input  logic [PRIO_BITS-1:0] bestPrio,
  input  logic                 nmiPend,
  input  logic                 ack,
  input  logic                 excReturn,
  output dpStrobe_t            strb,
  output logic                 reqValid,
  output logic [EXC_W-1:0]     reqExcNum,
  output logic [PRIO_BITS:0]   runLevel
);
  localparam int LVL_W = PRIO_BITS + 1;
  localparam int DEPTH = (1 << PRIO_BITS) + 1;
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] IDLE = '1;

  logic [LVL_W-1:0] stkLvl [DEPTH];
  logic             stkNmi [DEPTH];
  logic [IDX_W-1:0] stkIdx [DEPTH];
  logic [SP_W-1:0]  sp, topIdx;

  logic             candValid, accept, pop;
  logic [LVL_W-1:0] candLvl;

  assign topIdx   = sp - 1'b1;
  assign runLevel = (sp == '0) ? IDLE : stkLvl[topIdx];

  assign candValid = nmiPend || bestValid;
  assign candLvl   = nmiPend ? '0 : LVL_W'(bestPrio) + 1'b1;
  assign reqValid  = candValid && candLvl < runLevel;
  assign reqExcNum = nmiPend ? EXC_W'(EXC_NMI)
                             : EXC_W'(EXC_IRQ_BASE) + EXC_W'(bestIdx);

  assign accept = ack && reqValid;
  assign pop    = excReturn && !accept && sp != '0;

  always_comb begin
    strb.ackIrq = accept && !nmiPend;
    strb.ackNmi = accept && nmiPend;
    strb.ackIdx = bestIdx;
    strb.retIrq = pop && !stkNmi[topIdx];
    strb.retIdx = stkIdx[topIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stkLvl[i] <= IDLE;
        stkNmi[i] <= 1'b0;
        stkIdx[i] <= '0;
      end
    end else if (accept) begin
      stkLvl[sp] <= candLvl;
      stkNmi[sp] <= nmiPend;
      stkIdx[sp] <= bestIdx;
      sp         <= sp + 1'b1;
    end else if (pop) begin
      sp <= topIdx;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int  NUM_IRQ   = 32,
  parameter int  PRIO_BITS = 2,
  localparam int ADDR_W    = $clog2(ADDR_PRIO + (NUM_IRQ + 3) / 4),
  localparam int EXC_W     = $clog2(EXC_IRQ_BASE + NUM_IRQ)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_IRQ-1:0]   irqIn,
  input  logic                 nmiIn,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 reqValid,
  output logic [EXC_W-1:0]     reqExcNum,
  input  logic                 ack,
  input  logic                 excReturn,
  output logic [PRIO_BITS:0]   runLevel
);
  dpStrobe_t            strb;
  logic                 bestValid, nmiPend;
  logic [IDX_W-1:0]     bestIdx;
  logic [PRIO_BITS-1:0] bestPrio;

  irq_nest_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .irqIn, .nmiIn,
    .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData), .rdData(regRdData),
    .strb, .bestValid, .bestIdx, .bestPrio, .nmiPend
  );

  irq_nest_ctl #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .EXC_W(EXC_W)) u_ctl (
    .clk, .rstN, .bestValid, .bestIdx, .bestPrio, .nmiPend,
    .ack, .excReturn, .strb, .reqValid, .reqExcNum, .runLevel
  );
endmodule

// File: rtl/irq_nest_chk.sv
`timescale 1ns/1ps
module irq_nest_chk
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 2,
  parameter int EXC_W     = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               nmiIn,
  input logic               ack,
  input logic               excReturn,
  input logic               reqValid,
  input logic [EXC_W-1:0]   reqExcNum,
  input logic [PRIO_BITS:0] runLevel
);
  localparam logic [PRIO_BITS:0] IDLE = '1;

  // R2: offered numbers are the non-maskable one or inside the line range
  a_r2_exc_range: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqExcNum == EXC_W'(EXC_NMI) ||
                  (reqExcNum >= EXC_W'(EXC_IRQ_BASE) &&
                   int'(reqExcNum) < EXC_IRQ_BASE + NUM_IRQ)));

  // R5 / R6: an accepted offer always raises urgency
  a_r6_ack_deepens: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ack) |=> runLevel < $past(runLevel));

  // R7: a return from a handler always lowers urgency
  a_r7_ret_unwinds: assert property (@(posedge clk) disable iff (!rstN)
    (excReturn && !(reqValid && ack) && runLevel != IDLE) |=> runLevel > $past(runLevel));

  // R10: a non-maskable request is running or offered one cycle later
  a_r10_nmi_wins: assert property (@(posedge clk) disable iff (!rstN)
    nmiIn |=> (runLevel == '0 || (reqValid && reqExcNum == EXC_W'(EXC_NMI))));

  // R11: an acknowledge with nothing offered leaves the level alone
  a_r11_stray_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !reqValid && !excReturn) |=> $stable(runLevel));
endmodule

bind irq_nest_ctrl irq_nest_chk #(
  .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .EXC_W(EXC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .ack(ack), .excReturn(excReturn),
  .reqValid(reqValid), .reqExcNum(reqExcNum), .runLevel(runLevel)
);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;
  localparam int NUM_IRQ   = 32;
  localparam int PRIO_BITS = 2;
  localparam int ADDR_W    = $clog2(8 + (NUM_IRQ + 3) / 4);
  localparam int EXC_W     = $clog2(16 + NUM_IRQ);
  localparam int IDLE      = (1 << (PRIO_BITS + 1)) - 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_IRQ-1:0] irqIn = '0;
  logic               nmiIn = 1'b0;
  logic               regWrEn = 1'b0;
  logic [ADDR_W-1:0]  regAddr = '0;
  logic [31:0]        regWrData = '0;
  logic [31:0]        regRdData;
  logic               reqValid;
  logic [EXC_W-1:0]   reqExcNum;
  logic               ack = 1'b0;
  logic               excReturn = 1'b0;
  logic [PRIO_BITS:0] runLevel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_nest_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) i_irq_nest_ctrl (
    .clk, .rstN, .irqIn, .nmiIn, .regWrEn, .regAddr, .regWrData, .regRdData,
    .reqValid, .reqExcNum, .ack, .excReturn, .runLevel
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = ADDR_W'(a); regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    regAddr = ADDR_W'(a);
    #1;
    d = int'(regRdData);
  endtask

  task automatic doAck();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic doRet();
    excReturn = 1'b1; tick(); excReturn = 1'b0;
  endtask

  task automatic t_reset();
    int d;
    chk("R1 reqValid", int'(reqValid), 0);
    chk("R1 runLevel", int'(runLevel), IDLE);
    rd(0, d); chk("R1 enable", d, 0);
    rd(2, d); chk("R1 pending", d, 0);
    rd(4, d); chk("R1 active", d, 0);
    rd(15, d); chk("R1 prio", d, 0);
  endtask

  task automatic t_prio_reg();
    int d;
    wr(9, 32'hFFFF_FFFF);
    rd(9, d); chk("R3 low bits zero", d, 32'hC0C0_C0C0);
    wr(9, 32'h4080_00FF);
    rd(9, d); chk("R3 byte lanes", d, 32'h4080_00C0);
    wr(9, 32'h0);
  endtask

  task automatic t_basic();
    int d;
    wr(0, 32'h8);
    irqIn[3] = 1'b1;
    tick();
    chk("R2 offered", int'(reqValid), 1);
    chk("R2 exc num", int'(reqExcNum), 19);
    irqIn[3] = 1'b0;
    doAck();
    chk("R6 level", int'(runLevel), 1);
    rd(4, d); chk("R6 active", d, 32'h8);
    rd(2, d); chk("R6 pending cleared", d, 0);
    doRet();
    chk("R7 level idle", int'(runLevel), IDLE);
    rd(4, d); chk("R7 active cleared", d, 0);
    irqIn[31] = 1'b1; wr(0, 32'h8000_0000); tick();
    chk("R2 top line", int'(reqExcNum), 47);
    irqIn[31] = 1'b0; wr(3, 32'h8000_0000); wr(1, 32'h8000_0008);
  endtask

  task automatic t_arb();
    int d;
    wr(8, 32'h0080_0000);   // line 2 -> value 2
    wr(9, 32'h0000_4000);   // line 5 -> value 1
    wr(10, 32'h0000_4000);  // line 9 -> value 1
    wr(0, 32'h0000_0224);
    wr(2, 32'h0000_0224);
    chk("R4 tie lowest index", int'(reqExcNum), 21);
    doAck();
    chk("R6 level line5", int'(runLevel), 2);
    chk("R5 equal waits", int'(reqValid), 0);
    doRet();
    chk("R5 offered after return", int'(reqExcNum), 25);
    doAck();
    chk("R5 lower waits", int'(reqValid), 0);
    doRet();
    chk("R4 last left", int'(reqExcNum), 18);
    doAck(); doRet();
    chk("R7 back idle", int'(runLevel), IDLE);
    wr(2, 32'h4);
    doAck();
    chk("R6 level line2", int'(runLevel), 3);
    wr(2, 32'h20);
    chk("R5 preempt", int'(reqValid), 1);
    chk("R5 preempt num", int'(reqExcNum), 21);
    doAck();
    rd(4, d); chk("R6 nested active", d, 32'h24);
    doRet();
    chk("R7 restore", int'(runLevel), 3);
    rd(4, d); chk("R7 inner cleared", d, 32'h4);
    doRet();
    chk("R7 idle", int'(runLevel), IDLE);
  endtask

  task automatic t_mask();
    int d;
    wr(1, 32'h220);
    wr(2, 32'h20);
    chk("R9 masked", int'(reqValid), 0);
    rd(2, d); chk("R9 pending kept", d, 32'h20);
    irqIn[9] = 1'b1; tick(); tick();
    rd(2, d); chk("R9 disabled line no set", d, 32'h20);
    irqIn[9] = 1'b0;
    wr(0, 32'h20);
    rd(0, d); chk("R8 enable readback", d, 32'h24);
    chk("R9 unmasked offer", int'(reqExcNum), 21);
    wr(3, 32'h20);
    chk("R8 sw clear", int'(reqValid), 0);
    rd(3, d); chk("R8 pending readback", d, 0);
  endtask

  task automatic t_nmi();
    wr(2, 32'h20);
    doAck();
    chk("R6 level before nmi", int'(runLevel), 2);
    nmiIn = 1'b1; tick(); nmiIn = 1'b0;
    chk("R10 nmi offered", int'(reqValid), 1);
    chk("R10 nmi num", int'(reqExcNum), 2);
    doAck();
    chk("R10 nmi level", int'(runLevel), 0);
    nmiIn = 1'b1; tick(); nmiIn = 1'b0;
    chk("R10 no self nest", int'(reqValid), 0);
    doRet();
    chk("R7 back to handler", int'(runLevel), 2);
    chk("R10 nmi again", int'(reqExcNum), 2);
    doAck(); doRet(); doRet();
    chk("R7 unwound", int'(runLevel), IDLE);
  endtask

  task automatic t_ignore();
    int d;
    doAck();
    chk("R11 stray ack level", int'(runLevel), IDLE);
    rd(4, d); chk("R11 stray ack active", d, 0);
    doRet();
    chk("R11 stray return", int'(runLevel), IDLE);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_prio_reg();
    t_basic();
    t_arb();
    t_mask();
    t_nmi();
    t_ignore();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule